// File: doc/BRIEF.md
# Two-Space Byte Memory Access Sequencer

This block carries out single-byte and two-byte (big-endian) loads and stores through a memory port that is one byte wide. The port reaches two separate spaces: main RAM, addressed with 16 bits, and a device space, addressed with 8 bits. The `mem_dev` select tells the two spaces apart. A request states:

- the space and the addressing mode;
- the size, and whether it is a load or a store;
- an address or offset;
- the current program counter;
- the store data.

The sequencer forms the effective address. A word access takes two byte accesses, high byte first. The address is incremented between them, and this increment is computed while the first byte access is on the port.

Load results come back as a 16-bit value in which the fetched byte or bytes sit where a big-endian register expects them. Stores finish with a one-cycle completion pulse. Between accepting a request and completing it the block reports busy and takes no new work. The memory returns read data one cycle after the read strobe.

Top module: `bytemem_seq`

## Requirements
- R1: With `req_space`=0 (RAM) and `req_mode`=0 (absolute) or 3 (treated as absolute), the first access address is `req_addr` unchanged.
- R2: With `req_space`=0 and `req_mode`=1 (zero page), the first access address is `req_addr[7:0]` zero-extended to 16 bits.
- R3: With `req_space`=0 and `req_mode`=2 (relative), the first access address is `req_pc` plus `req_addr[7:0]` sign-extended, modulo 2^16.
- R4: With `req_space`=1 (device), every access drives `mem_dev`=1 and an address equal to `req_addr[7:0]` zero-extended, for any mode. RAM accesses drive `mem_dev`=0.
- R5: A byte load (`req_word`=0, `req_write`=0) makes one read and returns `rdata`={8'h00, byte read}. `done` pulses on the 3rd rising edge after the accepting edge.
- R6: A word load (`req_word`=1) reads address A, then A+1, and returns `rdata`={byte at A, byte at A+1}. `done` pulses on the 4th edge after acceptance.
- R7: A byte store (`req_write`=1) makes one write of `req_wdata[7:0]` to A. `done` pulses on the 2nd edge after acceptance.
- R8: A word store writes `req_wdata[15:8]` to A and then `req_wdata[7:0]` to A+1. `done` pulses on the 3rd edge after acceptance.
- R9: The second address of a word access wraps modulo 2^16 for absolute and relative RAM accesses. It wraps modulo 2^8, with the upper byte held at zero, for zero-page and device accesses.
- R10: `busy` rises on the edge that accepts a request and stays high through the `done` cycle, then falls. A `req_valid` seen while busy is ignored, whatever its fields.
- R11: After reset, `busy`, `done` and `mem_en` are 0 and `rdata` is 0.
- R12: Read data is taken from `mem_rdata` in the cycle after the read strobe. `rdata` keeps its value after `done` until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when not busy |
| req_space | input | 1 | 0 = RAM, 1 = device space |
| req_mode | input | 2 | 0 absolute, 1 zero page, 2 PC-relative, 3 absolute |
| req_word | input | 1 | 0 = byte, 1 = big-endian word |
| req_write | input | 1 | 0 = load, 1 = store |
| req_addr | input | 16 | Absolute address, or 8-bit address/offset in bits 7:0 |
| req_pc | input | 16 | Current program counter for relative mode |
| req_wdata | input | 16 | Store data; byte stores use bits 7:0 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Load result |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write access |
| mem_dev | output | 1 | 1 = device space, 0 = RAM |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Read byte, valid one cycle after a read strobe |

## Verification
Counted from the edge that accepts a request, `done` is due after 2 edges for a byte store, 3 for a word store or byte load, and 4 for a word load. `busy` must hold through that same edge and be low one edge later. The bench samples both at every falling edge in that window and compares them with the expected latency for the access kind. It logs each memory strobe at falling edges and checks `rdata` at the `done` cycle and again one cycle later. The memory model answers a read one cycle after the strobe and drives filler otherwise, so capturing in the wrong cycle shows up as a value mismatch.

// File: rtl/bms_pkg.sv
package bms_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ACC0 = 3'd1,
        ST_ACC1 = 3'd2,
        ST_CAP  = 3'd3,
        ST_FIN  = 3'd4
    } seq_st_e;

    localparam logic       SPACE_RAM = 1'b0;
    localparam logic       SPACE_DEV = 1'b1;

    localparam logic [1:0] MODE_ABS  = 2'd0;
    localparam logic [1:0] MODE_ZP   = 2'd1;
    localparam logic [1:0] MODE_REL  = 2'd2;

endpackage

// File: rtl/bms_addr_gen.sv
module bms_addr_gen
    import bms_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 8
) (
    input  logic          space,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] pc,
    output logic [AW-1:0] ea,
    output logic          narrow
);
    localparam int HW = AW - SW;

    logic [SW-1:0] short_a;
    logic [AW-1:0] zext_a;
    logic [AW-1:0] sext_a;
    logic [AW-1:0] rel_a;

    assign short_a = base[SW-1:0];
    assign zext_a  = {{HW{1'b0}}, short_a};
    assign sext_a  = {{HW{short_a[SW-1]}}, short_a};
    assign rel_a   = pc + sext_a;

    always_comb begin
        ea     = zext_a;
        narrow = 1'b1;
        if (space == SPACE_RAM) begin
            unique case (mode)
                MODE_ZP: begin
                    ea     = zext_a;
                    narrow = 1'b1;
                end
                MODE_REL: begin
                    ea     = rel_a;
                    narrow = 1'b0;
                end
                default: begin
                    ea     = base;
                    narrow = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/bms_addr_incr.sv
module bms_addr_incr #(
    parameter int AW = 16,
    parameter int SW = 8
) (
    input  logic [AW-1:0] cur,
    input  logic          narrow,
    output logic [AW-1:0] nxt
);
    generate
        if (SW >= AW) begin : g_flat
            logic unused_narrow;
            assign unused_narrow = narrow;
            assign nxt = cur + {{(AW-1){1'b0}}, 1'b1};
        end else begin : g_split
            logic [SW-1:0]    lo_inc;
            logic             lo_carry;
            logic [AW-SW-1:0] hi_inc;

            assign {lo_carry, lo_inc} = {1'b0, cur[SW-1:0]} + {{SW{1'b0}}, 1'b1};
            assign hi_inc = cur[AW-1:SW] + {{(AW-SW-1){1'b0}}, lo_carry};
            assign nxt    = narrow ? {cur[AW-1:SW], lo_inc} : {hi_inc, lo_inc};
        end
    endgenerate

endmodule

// File: rtl/bms_rd_capture.sv
module bms_rd_capture #(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            cap_hi,
    input  logic            cap_lo,
    input  logic [BW-1:0]   din,
    output logic [2*BW-1:0] word
);
    logic [BW-1:0] hi_d, hi_q;
    logic [BW-1:0] lo_d, lo_q;

    always_comb begin
        hi_d = hi_q;
        lo_d = lo_q;
        if (clr) begin
            hi_d = '0;
            lo_d = '0;
        end else begin
            if (cap_hi) hi_d = din;
            if (cap_lo) lo_d = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    assign word = {hi_q, lo_q};

endmodule

// File: rtl/bytemem_seq.sv
module bytemem_seq
    import bms_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 8,
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_space,
    input  logic [1:0]      req_mode,
    input  logic            req_word,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [AW-1:0]   req_pc,
    input  logic [2*BW-1:0] req_wdata,
    output logic            busy,
    output logic            done,
    output logic [2*BW-1:0] rdata,
    output logic            mem_en,
    output logic            mem_we,
    output logic            mem_dev,
    output logic [AW-1:0]   mem_addr,
    output logic [BW-1:0]   mem_wdata,
    input  logic [BW-1:0]   mem_rdata
);
    localparam int DW = 2 * BW;

    typedef struct packed {
        seq_st_e       st;
        logic [AW-1:0] addr;
        logic          narrow;
        logic          word;
        logic          write;
        logic          space;
        logic [DW-1:0] wdata;
        logic          busy;
    } seq_s;

    seq_s seq_d, seq_q;

    logic [AW-1:0] ea;
    logic          ea_narrow;
    logic [AW-1:0] addr_nxt;
    logic          cap_clr;
    logic          cap_hi;
    logic          cap_lo;

    bms_addr_gen #(.AW(AW), .SW(SW)) u_addr_gen (
        .space  (req_space),
        .mode   (req_mode),
        .base   (req_addr),
        .pc     (req_pc),
        .ea     (ea),
        .narrow (ea_narrow)
    );

    bms_addr_incr #(.AW(AW), .SW(SW)) u_addr_incr (
        .cur    (seq_q.addr),
        .narrow (seq_q.narrow),
        .nxt    (addr_nxt)
    );

    bms_rd_capture #(.BW(BW)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cap_clr),
        .cap_hi (cap_hi),
        .cap_lo (cap_lo),
        .din    (mem_rdata),
        .word   (rdata)
    );

    always_comb begin
        seq_d     = seq_q;
        cap_clr   = 1'b0;
        cap_hi    = 1'b0;
        cap_lo    = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = seq_q.wdata[BW-1:0];
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.st     = ST_ACC0;
                    seq_d.addr   = ea;
                    seq_d.narrow = ea_narrow;
                    seq_d.word   = req_word;
                    seq_d.write  = req_write;
                    seq_d.space  = req_space;
                    seq_d.wdata  = req_wdata;
                    seq_d.busy   = 1'b1;
                    cap_clr      = 1'b1;
                end
            end
            ST_ACC0: begin
                mem_en = 1'b1;
                mem_we = seq_q.write;
                if (seq_q.word) begin
                    mem_wdata  = seq_q.wdata[DW-1:BW];
                    seq_d.addr = addr_nxt;
                    seq_d.st   = ST_ACC1;
                end else begin
                    seq_d.st   = seq_q.write ? ST_FIN : ST_CAP;
                end
            end
            ST_ACC1: begin
                mem_en = 1'b1;
                mem_we = seq_q.write;
                cap_hi = !seq_q.write;
                seq_d.st = seq_q.write ? ST_FIN : ST_CAP;
            end
            ST_CAP: begin
                cap_lo   = 1'b1;
                seq_d.st = ST_FIN;
            end
            ST_FIN: begin
                seq_d.st   = ST_IDLE;
                seq_d.busy = 1'b0;
            end
            default: begin
                seq_d.st   = ST_IDLE;
                seq_d.busy = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st     <= ST_IDLE;
            seq_q.addr   <= '0;
            seq_q.narrow <= 1'b0;
            seq_q.word   <= 1'b0;
            seq_q.write  <= 1'b0;
            seq_q.space  <= 1'b0;
            seq_q.wdata  <= '0;
            seq_q.busy   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy     = seq_q.busy;
    assign done     = (seq_q.st == ST_FIN);
    assign mem_dev  = seq_q.space;
    assign mem_addr = seq_q.addr;

endmodule

// File: rtl/bms_chk.sv
module bms_chk #(
    parameter int AW = 16,
    parameter int SW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          busy,
    input logic          done,
    input logic          mem_en,
    input logic          mem_we,
    input logic          mem_dev,
    input logic [AW-1:0] mem_addr
);
    // R10
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R10
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R10
    access_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en || done) |-> busy);

    // R4
    dev_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_dev) |-> (mem_addr[AW-1:SW] == '0));

    // R9
    second_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && $past(mem_en)) |->
            ((mem_addr == $past(mem_addr) + 1'b1) ||
             ((mem_addr[AW-1:SW] == $past(mem_addr[AW-1:SW])) &&
              (mem_addr[SW-1:0] == $past(mem_addr[SW-1:0]) + 1'b1))));

    // R8
    pair_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && $past(mem_en)) |-> ($stable(mem_we) && $stable(mem_dev)));

endmodule

bind bytemem_seq bms_chk #(.AW(AW), .SW(SW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_dev   (mem_dev),
    .mem_addr  (mem_addr)
);

// File: tb/bytemem_seq_tb_top.sv
`timescale 1ns/1ps
module bytemem_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_space = 1'b0;
    logic [1:0]  req_mode = 2'd0;
    logic        req_word = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_pc = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, mem_en, mem_we, mem_dev;
    logic [15:0] rdata, mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'hEE;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    bytemem_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_space(req_space),
        .req_mode(req_mode), .req_word(req_word), .req_write(req_write),
        .req_addr(req_addr), .req_pc(req_pc), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .mem_en(mem_en), .mem_we(mem_we),
        .mem_dev(mem_dev), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] mdl(input logic [15:0] a, input logic d);
        return (a[7:0] * 8'd3) ^ a[15:8] ^ (d ? 8'h5A : 8'hC3);
    endfunction

    // memory model: one-cycle read latency, filler otherwise (R12)
    always @(posedge clk) begin
        if (mem_en && !mem_we) mem_rdata <= mdl(mem_addr, mem_dev);
        else                   mem_rdata <= 8'hEE;
    end

    // access monitor
    int          acc_n = 0;
    logic [15:0] m_addr [4];
    logic        m_we   [4];
    logic        m_dev  [4];
    logic [7:0]  m_wd   [4];

    always @(negedge clk) begin
        if (mem_en) begin
            if (acc_n < 4) begin
                m_addr[acc_n] = mem_addr;
                m_we[acc_n]   = mem_we;
                m_dev[acc_n]  = mem_dev;
                m_wd[acc_n]   = mem_wdata;
            end
            acc_n = acc_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_txn(input logic sp, input logic [1:0] md, input logic wd,
                           input logic wr, input logic [15:0] a, input logic [15:0] pc,
                           input logic [15:0] wdat, input bit hold);
        logic [15:0] ea, ea2, exp_rd, got_rd, held_rd;
        logic        nar;
        int          lat, n_exp, bad_busy, bad_done;
        string       atag, ktag;
        nar = sp || (md == 2'd1);
        if (sp)              begin ea = {8'h00, a[7:0]};                 atag = "R4"; end
        else if (md == 2'd1) begin ea = {8'h00, a[7:0]};                 atag = "R2"; end
        else if (md == 2'd2) begin ea = pc + {{8{a[7]}}, a[7:0]};        atag = "R3"; end
        else                 begin ea = a;                               atag = "R1"; end
        ea2 = nar ? {8'h00, ea[7:0] + 8'd1} : ea + 16'd1;
        if (wr) begin lat = wd ? 3 : 2; ktag = wd ? "R8" : "R7"; end
        else    begin lat = wd ? 4 : 3; ktag = wd ? "R6" : "R5"; end
        n_exp  = wd ? 2 : 1;
        exp_rd = wd ? {mdl(ea, sp), mdl(ea2, sp)} : {8'h00, mdl(ea, sp)};

        @(negedge clk);
        acc_n     = 0;
        req_valid = 1'b1; req_space = sp; req_mode = md; req_word = wd;
        req_write = wr; req_addr = a; req_pc = pc; req_wdata = wdat;
        @(posedge clk);
        bad_busy = 0; bad_done = 0; got_rd = '0; held_rd = '0;
        for (int i = 1; i <= lat + 1; i++) begin
            @(negedge clk);
            if (i == 1) begin
                if (hold) begin
                    req_addr = ~a; req_write = ~wr; req_word = ~wd;
                    req_space = ~sp; req_wdata = ~wdat;
                end else begin
                    req_valid = 1'b0;
                end
            end
            if (i == lat) req_valid = 1'b0;
            if (busy !== (i <= lat)) bad_busy++;
            if (done !== (i == lat)) bad_done++;
            if (i == lat)     got_rd  = rdata;
            if (i == lat + 1) held_rd = rdata;
        end
        #1;
        // R10
        chk(bad_busy == 0, "R10", "busy window", bad_busy, 0);
        chk(bad_done == 0, ktag, "done latency", bad_done, 0);
        chk(acc_n == n_exp, ktag, "access count", acc_n, n_exp);
        if (acc_n >= 1) begin
            chk(m_addr[0] == ea && m_we[0] == wr && m_dev[0] == sp, atag, "first access",
                {m_dev[0], m_we[0], m_addr[0]}, {sp, wr, ea});
            if (wr)
                chk(m_wd[0] == (wd ? wdat[15:8] : wdat[7:0]), ktag, "first store byte",
                    m_wd[0], wd ? wdat[15:8] : wdat[7:0]);
        end
        if (wd && acc_n >= 2) begin
            // R9
            chk(m_addr[1] == ea2 && m_we[1] == wr && m_dev[1] == sp, "R9", "second access",
                {m_dev[1], m_we[1], m_addr[1]}, {sp, wr, ea2});
            if (wr) chk(m_wd[1] == wdat[7:0], "R8", "second store byte", m_wd[1], wdat[7:0]);
        end
        if (!wr) begin
            chk(got_rd == exp_rd, ktag, "load result", got_rd, exp_rd);
            // R12
            chk(held_rd == exp_rd, "R12", "result held", held_rd, exp_rd);
        end
    endtask

    initial begin
        logic [15:0] addrs [4];
        logic [15:0] pcs   [2];
        addrs[0] = 16'h1234; addrs[1] = 16'hFFFF; addrs[2] = 16'h80FF; addrs[3] = 16'h0080;
        pcs[0]   = 16'h0010; pcs[1]   = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R11
        chk(busy === 1'b0 && done === 1'b0 && mem_en === 1'b0, "R11", "reset controls",
            {busy, done, mem_en}, 0);
        chk(rdata === 16'h0000, "R11", "reset rdata", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int s = 0; s < 2; s++)
            for (int m = 0; m < 4; m++)
                for (int w = 0; w < 2; w++)
                    for (int r = 0; r < 2; r++)
                        for (int ai = 0; ai < 4; ai++)
                            for (int pi = 0; pi < 2; pi++)
                                run_txn(s[0], m[1:0], w[0], r[0], addrs[ai], pcs[pi],
                                        addrs[ai] ^ 16'hA55A ^ pcs[pi], ai == 2);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule